// File: doc/BRIEF.md
# Packed Horizontal Subtract Unit

This block is a SIMD datapath that folds two packed integer operands into one packed result. Each operand is split into adjacent pairs of signed elements, and each pair becomes one difference: the lower-indexed element minus the higher-indexed one. The first operand's differences go into the low half of each 128-bit lane and the second operand's differences go into the high half. Elements are either 16-bit words or 32-bit doublewords. The vector width is 64, 128 or 256 bits. At 256 bits the packing repeats inside each lane and does not span the whole vector.

The destination is a 256-bit register that loads on a one-cycle `valid_i` strobe. At 128-bit width, `zero_upper_i` chooses between keeping the destination bits above bit 127 (the legacy form) and clearing them. An alignment check covers the case where the second operand is a memory operand in the legacy 128-bit form. If its low address bits show it is not 16-byte aligned, the unit raises a fault pulse and leaves the destination as it was. Decoding, register files, memory access and fault delivery are handled elsewhere.

Top module: `hsub_unit`

## Requirements
- R1: Each result element is the lower-indexed element of its pair minus the higher-indexed one. The subtraction wraps modulo 2^N for element width N, with no saturation. For example, a word 0x8000 minus a word 0x0001 gives 0x7FFF.
- R2: With `width_sel_i`=1 (128 bits), the pair differences of `src1_i[127:0]` fill `dest_o[63:0]` in ascending pair order, and those of `src2_i[127:0]` fill `dest_o[127:64]`. This holds for words (`dword_i`=0) and for doublewords (`dword_i`=1).
- R3: With `width_sel_i`=0 (64 bits), the differences of `src1_i[63:0]` fill `dest_o[31:0]`, those of `src2_i[63:0]` fill `dest_o[63:32]`, and `dest_o[255:64]` keeps its previous value.
- R4: With `width_sel_i`=2 (256 bits), each 128-bit lane follows the R2 packing on its own. `dest_o[191:128]` takes the differences of `src1_i[255:128]` and `dest_o[255:192]` takes those of `src2_i[255:128]`.
- R5: At 128-bit width, `zero_upper_i`=1 clears `dest_o[255:128]`, and `zero_upper_i`=0 leaves it unchanged.
- R6: A strobe raises `gp_fault_o` in the next cycle only when all of these hold: 128-bit width, `mem_src_i`=1, `zero_upper_i`=0 and `addr_lo_i`≠0. A faulting strobe leaves `dest_o` unchanged. Aligned, register-sourced, zero-upper and other-width strobes never fault.
- R7: `dest_o` changes only in the cycle after a strobe. With no strobe, or with the reserved code `width_sel_i`=3, it holds.
- R8: After reset, `dest_o` is zero and `gp_fault_o` is low.
- R9: `gp_fault_o` is high for exactly one cycle per faulting strobe, and is low after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| src1_i | input | 256 | First packed operand |
| src2_i | input | 256 | Second packed operand |
| dword_i | input | 1 | 0 = 16-bit elements, 1 = 32-bit elements |
| width_sel_i | input | 2 | 0 = 64, 1 = 128, 2 = 256 bits, 3 = reserved |
| zero_upper_i | input | 1 | 1 = clear bits above 127 at 128-bit width |
| mem_src_i | input | 1 | Second operand came from memory |
| addr_lo_i | input | 4 | Low address bits of the memory operand |
| dest_o | output | 256 | Destination register |
| gp_fault_o | output | 1 | Alignment fault pulse |

## Verification
The hardest case to reach is preservation: the bits kept by the legacy 128-bit form, the 64-bit form and a faulting strobe only show an error if they held a distinctive non-zero value beforehand. Each operation is therefore preceded by a 256-bit strobe of random data. The sweep then covers every combination of element size, width code, upper mode, operand source and a set of aligned and misaligned address values. Wraparound is forced with operands made of alternating 0x8000/0x7FFF words and 0x80000000/0x7FFFFFFF doublewords.

// File: rtl/hsub_pkg.sv
package hsub_pkg;
  typedef enum logic [1:0] {
    VW_64  = 2'd0,
    VW_128 = 2'd1,
    VW_256 = 2'd2,
    VW_RSV = 2'd3
  } vw_e;

  // Wrapping differences; no saturation.
  function automatic logic [15:0] wsub16(input logic [15:0] lo, input logic [15:0] hi);
    return lo - hi;
  endfunction

  function automatic logic [31:0] wsub32(input logic [31:0] lo, input logic [31:0] hi);
    return lo - hi;
  endfunction
endpackage

// File: rtl/hsub_lane.sv
module hsub_lane
  import hsub_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              dword_i,
  output logic [LANE_W-1:0] y_o
);
  localparam int HALF = LANE_W / 2;
  localparam int NWP  = LANE_W / 32;
  localparam int NDP  = LANE_W / 64;

  logic [LANE_W-1:0] y_word;
  logic [LANE_W-1:0] y_dword;

  always_comb begin
    y_word = '0;
    for (int k = 0; k < NWP; k++) begin
      y_word[16*k +: 16]        = wsub16(a_i[32*k +: 16], a_i[32*k+16 +: 16]);
      y_word[HALF + 16*k +: 16] = wsub16(b_i[32*k +: 16], b_i[32*k+16 +: 16]);
    end
  end

  always_comb begin
    y_dword = '0;
    for (int k = 0; k < NDP; k++) begin
      y_dword[32*k +: 32]        = wsub32(a_i[64*k +: 32], a_i[64*k+32 +: 32]);
      y_dword[HALF + 32*k +: 32] = wsub32(b_i[64*k +: 32], b_i[64*k+32 +: 32]);
    end
  end

  assign y_o = dword_i ? y_dword : y_word;

  // Adding the higher element back must restore the lower element.
  always_comb begin
    if (!dword_i) begin
      AST_LANE_WORD_SUM: assert (16'(y_o[15:0] + a_i[31:16]) == a_i[15:0]) else $error("lane word"); // R1
    end else begin
      AST_LANE_DWORD_SUM: assert (32'(y_o[HALF +: 32] + b_i[63:32]) == b_i[31:0]) else $error("lane dword"); // R1
    end
  end
endmodule

// File: rtl/hsub_align.sv
module hsub_align
  import hsub_pkg::*;
#(
  parameter int ALIGN_B = 16,
  localparam int AW = $clog2(ALIGN_B)
) (
  input  logic          mem_src_i,
  input  logic          zero_upper_i,
  input  logic [1:0]    width_sel_i,
  input  logic [AW-1:0] addr_lo_i,
  output logic          fault_o
);
  logic legacy_w;
  logic misal_w;

  assign legacy_w = !zero_upper_i && (vw_e'(width_sel_i) == VW_128);
  assign misal_w  = |addr_lo_i;
  assign fault_o  = mem_src_i && legacy_w && misal_w;
endmodule

// File: rtl/hsub_unit.sv
module hsub_unit
  import hsub_pkg::*;
#(
  parameter int VEC_W    = 256,
  parameter int LANE_W   = 128,
  parameter int NARROW_W = 64,
  parameter int ALIGN_B  = 16,
  localparam int NLANES  = VEC_W / LANE_W,
  localparam int AW      = $clog2(ALIGN_B)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic             dword_i,
  input  logic [1:0]       width_sel_i,
  input  logic             zero_upper_i,
  input  logic             mem_src_i,
  input  logic [AW-1:0]    addr_lo_i,
  output logic [VEC_W-1:0] dest_o,
  output logic             gp_fault_o
);
  logic [VEC_W-1:0]    wide_res;
  logic [NARROW_W-1:0] nar_res;
  logic [VEC_W-1:0]    next_dest;
  logic                fault_c;
  logic                upd_c;
  logic                rsv_c;
  vw_e                 vw;

  assign vw = vw_e'(width_sel_i);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    hsub_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i     (src1_i[g*LANE_W +: LANE_W]),
      .b_i     (src2_i[g*LANE_W +: LANE_W]),
      .dword_i (dword_i),
      .y_o     (wide_res[g*LANE_W +: LANE_W])
    );
  end

  hsub_lane #(.LANE_W(NARROW_W)) u_narrow (
    .a_i     (src1_i[NARROW_W-1:0]),
    .b_i     (src2_i[NARROW_W-1:0]),
    .dword_i (dword_i),
    .y_o     (nar_res)
  );

  hsub_align #(.ALIGN_B(ALIGN_B)) u_align (
    .mem_src_i    (mem_src_i),
    .zero_upper_i (zero_upper_i),
    .width_sel_i  (width_sel_i),
    .addr_lo_i    (addr_lo_i),
    .fault_o      (fault_c)
  );

  always_comb begin
    next_dest = dest_o;
    case (vw)
      VW_64:  next_dest = {dest_o[VEC_W-1:NARROW_W], nar_res};
      VW_128: next_dest = {zero_upper_i ? {(VEC_W-LANE_W){1'b0}} : dest_o[VEC_W-1:LANE_W],
                           wide_res[LANE_W-1:0]};
      VW_256: next_dest = wide_res;
      default: next_dest = dest_o;
    endcase
  end

  assign rsv_c = (vw == VW_RSV);
  assign upd_c = valid_i && !fault_c && !rsv_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_o     <= '0;
      gp_fault_o <= 1'b0;
    end else begin
      gp_fault_o <= valid_i && fault_c;
      if (upd_c) dest_o <= next_dest;
    end
  end

  AST_FAULT_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fault_c) |=> $stable(dest_o)) else $error("fault updated dest"); // R6
  AST_FAULT_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fault_c) |-> (mem_src_i && vw == VW_128)) else $error("fault source"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || rsv_c) |=> $stable(dest_o)) else $error("dest moved"); // R7
  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && vw == VW_128 && zero_upper_i) |=> (dest_o[VEC_W-1:LANE_W] == '0)) else $error("upper not cleared"); // R5
  AST_NARROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && vw == VW_64) |=> $stable(dest_o[VEC_W-1:NARROW_W])) else $error("narrow upper"); // R3
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && fault_c) |=> !gp_fault_o) else $error("stray fault"); // R9
endmodule

// File: tb/sim_hsub_unit.sv
module sim_hsub_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [255:0] src1_i = '0;
  logic [255:0] src2_i = '0;
  logic         dword_i = 1'b0;
  logic [1:0]   width_sel_i = 2'd0;
  logic         zero_upper_i = 1'b0;
  logic         mem_src_i = 1'b0;
  logic [3:0]   addr_lo_i = 4'd0;
  logic [255:0] dest_o;
  logic         gp_fault_o;

  int checks = 0;
  int errors = 0;
  logic [255:0] model = '0;
  logic         done = 1'b0;

  always #4 clk = ~clk;

  hsub_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src1_i(src1_i), .src2_i(src2_i),
    .dword_i(dword_i), .width_sel_i(width_sel_i), .zero_upper_i(zero_upper_i),
    .mem_src_i(mem_src_i), .addr_lo_i(addr_lo_i), .dest_o(dest_o), .gp_fault_o(gp_fault_o)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // Element-indexed reference: result element j picks its lane, operand half and pair.
  function automatic logic [255:0] ref_ops(input logic [255:0] a, input logic [255:0] b,
                                           input logic d, input int w, input logic zu,
                                           input logic [255:0] old);
    logic [255:0] r;
    int lb, nl, esz, epl;
    r = old;
    lb = (w == 0) ? 64 : 128;
    nl = (w == 2) ? 2 : 1;
    esz = d ? 32 : 16;
    epl = lb / esz;
    if (w == 1 && zu) r[255:128] = '0;
    for (int j = 0; j < nl*epl; j++) begin
      int lane, p, k, base;
      logic [255:0] s;
      lane = j / epl;
      p = j % epl;
      s = (p < epl/2) ? a : b;
      k = p % (epl/2);
      base = lane*lb + 2*k*esz;
      if (d) r[lane*lb + p*32 +: 32] = s[base +: 32] + ~s[base+32 +: 32] + 32'd1;
      else   r[lane*lb + p*16 +: 16] = s[base +: 16] + ~s[base+16 +: 16] + 16'd1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic op(input logic [255:0] a, input logic [255:0] b, input logic d, input int w,
                    input logic zu, input logic ms, input logic [3:0] al, input string req);
    logic flt;
    flt = (w == 1) && ms && !zu && (al != 0);
    @(negedge clk);
    src1_i = a; src2_i = b; dword_i = d; width_sel_i = w[1:0];
    zero_upper_i = zu; mem_src_i = ms; addr_lo_i = al; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    if (!flt && w != 3) model = ref_ops(a, b, d, w, zu, model);
    check(req, dest_o, model);
    check("R6 fault flag", {255'd0, gp_fault_o}, {255'd0, flt});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset dest", dest_o, '0);
    check("R8 reset fault", {255'd0, gp_fault_o}, '0);
    rst_n = 1'b1;

    // R1 literal: 0x8000 - 0x0001 = 0x7FFF; 0x0001 - 0x8000 = 0x8001.
    op({240'd0, 16'h8001}, '0, 1'b0, 1, 1'b1, 1'b0, 4'd0, "R1 setup");
    op({224'd0, 16'h0001, 16'h8000}, {224'd0, 16'h8000, 16'h0001}, 1'b0, 1, 1'b1, 1'b0, 4'd0, "R1 wrap");
    check("R1 literal", {128'd0, dest_o[127:0]}, {128'd0, 48'd0, 16'h8001, 48'd0, 16'h7FFF});

    // Full sweep with a random 256-bit preload before each operation.
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 4; w++)
        for (int zu = 0; zu < 2; zu++)
          for (int ms = 0; ms < 2; ms++)
            for (int ai = 0; ai < 4; ai++) begin
              logic [3:0] al;
              string tag;
              al = (ai == 0) ? 4'd0 : (ai == 1) ? 4'd1 : (ai == 2) ? 4'd8 : 4'd15;
              tag = (w == 0) ? "R3 narrow" : (w == 1) ? "R2 R5 mid" : (w == 2) ? "R4 lanes" : "R7 reserved";
              op(rnd256(), rnd256(), 1'b0, 2, 1'b0, 1'b0, 4'd0, "R4 preload");
              op(rnd256(), rnd256(), d[0], w, zu[0], ms[0], al, tag);
            end

    // Wraparound corners on all widths.
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 3; w++) begin
        op(rnd256(), rnd256(), 1'b0, 2, 1'b0, 1'b0, 4'd0, "R4 preload");
        op({16{16'h7FFF, 16'h8000}} >> 0, {8{32'h8000_7FFF}}, d[0], w, 1'b0, 1'b0, 4'd0, "R1 corner word");
        op({4{32'h8000_0000, 32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF, 32'h8000_0000}}, d[0], w, 1'b0, 1'b0, 4'd0, "R1 corner dword");
      end

    // R7 / R9: idle cycles hold dest and keep fault low.
    op(rnd256(), rnd256(), 1'b1, 1, 1'b0, 1'b1, 4'd4, "R6 misaligned");
    repeat (3) begin
      @(negedge clk);
      src1_i = rnd256(); src2_i = rnd256(); width_sel_i = 2'd2;
      check("R7 idle hold", dest_o, model);
      check("R9 fault pulse", {255'd0, gp_fault_o}, '0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule